// File: doc/BRIEF.md
# Sector Checksum Scrambler

This block protects one sector of 524 data bytes with a three-byte running checksum and scrambles each byte with that checksum as it streams through. Bytes come in one per input handshake. Position 0, 1 and 2 of each three-byte group each feed their own 8-bit accumulator (lanes A, B and C). The add carries pass from lane to lane, and lane C is rotated once at the start of every group. Each data byte is XORed with a lane-dependent key.

In encode mode the block emits the scrambled bytes and then the three checksum bytes. In decode mode it takes scrambled bytes and emits the recovered data. It then takes three received checksum bytes and reports on a one-cycle done pulse whether they match the recomputed accumulators. The block holds no sector buffer. It sits in a byte stream between a data buffer and any later line coder.

Top module: `sector_scramble_cksum`

## Requirements
- R1: After reset, outValid and done are 0 and inReady is 1. Reset also clears the accumulators and the carry.
- R2: For the first byte of a group, the key is C rotated left by one bit, and the rotated C is stored. The carry becomes the old C bit 7. Then A = A + data + carry, the 9th sum bit becomes the carry, and the emitted byte is input XOR key.
- R3: For the second byte of a group, the key is the current A. Then B = B + data + carry, and the carry-out is kept.
- R4: For the third byte of a group, the key is the current B. Then C = C + data + carry, and the carry-out is kept.
- R5: The accumulators and the carry start from zero for every sector, including a sector that directly follows another one.
- R6: In encode mode, after the 524th data byte the block emits A, B and C in that order, and inReady stays 0 until the done pulse.
- R7: In encode mode, done is a one-cycle pulse with match 0. It appears in the same cycle that byte C is first presented on outData.
- R8: In decode mode, "data" in R2 to R4 means the recovered byte (input XOR key). The emitted byte is that recovered byte.
- R9: In decode mode, the three bytes after the data are taken as expected A, B and C and produce no output. In the cycle after the edge that accepts the third one, done pulses for one cycle, and match is 1 only if all three equal the recomputed accumulators.
- R10: The mode is sampled when the first byte of a sector is accepted. Changes to decodeMode later in the sector have no effect.
- R11: While outValid is 1 and outReady is 0, outValid stays 1 and outData keeps its value. No byte is lost or repeated under back-pressure on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| decodeMode | input | 1 | 1 = decode, 0 = encode; sampled on the first byte of a sector |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Block can take an input byte |
| inData | input | 8 | Input byte (data, or received checksum in decode) |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Sink takes the output byte |
| outData | output | 8 | Scrambled, recovered or checksum byte |
| done | output | 1 | One-cycle end-of-sector pulse |
| match | output | 1 | Checksum comparison result, valid with done |

## Verification
A byte accepted on a rising edge appears on outData right after that edge, because one output register sits between input and output. The bench drives on the falling edge, decides at that point whether a transfer will happen on the next rising edge, and compares outData at the following falling edge.

The encode done pulse is checked at the falling edge where byte C first shows. The decode done and match are checked exactly one falling edge after the edge that took the third checksum byte. Back-pressure patterns in both directions are applied, so any extra or missing byte in the stream shows up as a mismatch.

// File: rtl/scs_pkg.sv
package scs_pkg;

  localparam int LANES = 3;

  typedef enum logic {
    PH_DATA,
    PH_CKSUM
  } phase_e;

  // Strobes from the sequencer to the accumulator datapath.
  typedef struct packed {
    logic       clearAcc;
    logic       stepEn;
    logic [1:0] lane;
    logic       decode;
    logic       loadData;
    logic       loadCk;
    logic       compareEn;
  } strobe_t;

endpackage

// File: rtl/scs_datapath.sv
module scs_datapath
  import scs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] inData,
  output logic [BYTE_W-1:0] outData,
  output logic              matchNow
);

  logic [BYTE_W-1:0] acc [LANES];
  logic              carry;
  logic              mismatch;

  logic [BYTE_W-1:0] rotC, key, base, xored, plain, ckByte;
  logic              carryIn, laneHit;
  logic [BYTE_W:0]   sum;
  logic [LANES-1:0]  laneEq;

  for (genvar g = 0; g < LANES; g++) begin : gLaneEq
    assign laneEq[g] = (inData == acc[g]);
  end

  always_comb begin
    rotC = {acc[2][BYTE_W-2:0], acc[2][BYTE_W-1]};
    case (stb.lane)
      2'd0: begin
        key     = rotC;
        base    = acc[0];
        carryIn = acc[2][BYTE_W-1];
        ckByte  = acc[0];
        laneHit = laneEq[0];
      end
      2'd1: begin
        key     = acc[0];
        base    = acc[1];
        carryIn = carry;
        ckByte  = acc[1];
        laneHit = laneEq[1];
      end
      default: begin
        key     = acc[1];
        base    = acc[2];
        carryIn = carry;
        ckByte  = acc[2];
        laneHit = laneEq[2];
      end
    endcase
    xored    = inData ^ key;
    plain    = stb.decode ? xored : inData;
    sum      = {1'b0, base} + {1'b0, plain} + {{BYTE_W{1'b0}}, carryIn};
    matchNow = !mismatch && laneHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LANES; i++) acc[i] <= '0;
      carry    <= 1'b0;
      mismatch <= 1'b0;
      outData  <= '0;
    end else begin
      if (stb.clearAcc) begin
        for (int i = 0; i < LANES; i++) acc[i] <= '0;
        carry    <= 1'b0;
        mismatch <= 1'b0;
      end else begin
        if (stb.stepEn) begin
          case (stb.lane)
            2'd0: begin
              acc[2] <= rotC;
              acc[0] <= sum[BYTE_W-1:0];
            end
            2'd1:    acc[1] <= sum[BYTE_W-1:0];
            default: acc[2] <= sum[BYTE_W-1:0];
          endcase
          carry <= sum[BYTE_W];
        end
        if (stb.compareEn && !laneHit) mismatch <= 1'b1;
      end
      if (stb.loadData)    outData <= xored;
      else if (stb.loadCk) outData <= ckByte;
    end
  end

  // Group start rotates lane C by one bit (R2)
  assert_rotate_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepEn && stb.lane == 2'd0) |=>
      acc[2] == {$past(acc[2][BYTE_W-2:0]), $past(acc[2][BYTE_W-1])});

  // Sector end leaves every lane and the carry at zero (R5)
  assert_fresh_sector_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearAcc |=> (acc[0] == '0 && acc[1] == '0 && acc[2] == '0 && !carry));

endmodule

// File: rtl/scs_control.sv
module scs_control
  import scs_pkg::*;
#(
  parameter int SECTOR_BYTES = 524
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    decodeMode,
  input  logic    inValid,
  input  logic    outReady,
  input  logic    matchNow,
  output logic    inReady,
  output logic    outValid,
  output logic    done,
  output logic    matchFlag,
  output strobe_t stb
);

  localparam int               CNT_W     = $clog2(SECTOR_BYTES);
  localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(SECTOR_BYTES - 1);
  localparam logic [1:0]       LAST_LANE = 2'(LANES - 1);

  phase_e           phase;
  logic [CNT_W-1:0] byteCnt;
  logic [1:0]       lane;
  logic [1:0]       ckIdx;
  logic             modeReg;

  logic slotFree, firstByte, effMode, acceptIn, lastCk;

  always_comb begin
    slotFree  = !outValid || outReady;
    firstByte = (phase == PH_DATA) && (byteCnt == '0);
    effMode   = firstByte ? decodeMode : modeReg;
    stb        = '0;
    stb.decode = effMode;
    inReady    = 1'b0;
    acceptIn   = 1'b0;
    lastCk     = 1'b0;
    if (phase == PH_DATA) begin
      inReady      = slotFree;
      acceptIn     = inValid && slotFree;
      stb.lane     = lane;
      stb.stepEn   = acceptIn;
      stb.loadData = acceptIn;
    end else begin
      stb.lane = ckIdx;
      if (modeReg) begin
        inReady       = 1'b1;
        stb.compareEn = inValid;
        lastCk        = inValid && (ckIdx == LAST_LANE);
      end else begin
        stb.loadCk = slotFree;
        lastCk     = slotFree && (ckIdx == LAST_LANE);
      end
    end
    stb.clearAcc = lastCk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_DATA;
      byteCnt   <= '0;
      lane      <= '0;
      ckIdx     <= '0;
      modeReg   <= 1'b0;
      outValid  <= 1'b0;
      done      <= 1'b0;
      matchFlag <= 1'b0;
    end else begin
      done      <= lastCk;
      matchFlag <= lastCk && modeReg && matchNow;
      if (stb.loadData || stb.loadCk) outValid <= 1'b1;
      else if (outReady)              outValid <= 1'b0;
      if (acceptIn) begin
        if (firstByte) modeReg <= decodeMode;
        lane <= (lane == LAST_LANE) ? 2'd0 : lane + 2'd1;
        if (byteCnt == LAST_IDX) begin
          phase   <= PH_CKSUM;
          ckIdx   <= '0;
          byteCnt <= '0;
        end else begin
          byteCnt <= byteCnt + 1'b1;
        end
      end
      if (stb.compareEn || stb.loadCk) begin
        if (lastCk) begin
          phase <= PH_DATA;
          lane  <= '0;
          ckIdx <= '0;
        end else begin
          ckIdx <= ckIdx + 2'd1;
        end
      end
    end
  end

  // End-of-sector indication lasts exactly one cycle (R7)
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/sector_scramble_cksum.sv
module sector_scramble_cksum
  import scs_pkg::*;
#(
  parameter int SECTOR_BYTES = 524,
  parameter int BYTE_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              decodeMode,
  input  logic              inValid,
  output logic              inReady,
  input  logic [BYTE_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [BYTE_W-1:0] outData,
  output logic              done,
  output logic              match
);

  strobe_t stb;
  logic    matchNow;

  scs_control #(.SECTOR_BYTES(SECTOR_BYTES)) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .decodeMode(decodeMode),
    .inValid   (inValid),
    .outReady  (outReady),
    .matchNow  (matchNow),
    .inReady   (inReady),
    .outValid  (outValid),
    .done      (done),
    .matchFlag (match),
    .stb       (stb)
  );

  scs_datapath #(.BYTE_W(BYTE_W)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .inData  (inData),
    .outData (outData),
    .matchNow(matchNow)
  );

  // A stalled output byte is held unchanged (R11)
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

endmodule

// File: tb/sector_scramble_cksum_bench.sv
`timescale 1ns/1ps
module sector_scramble_cksum_bench;

  localparam int SB = 524;
  localparam int NV = 9;
  // [15] decode, [14:13] pattern, [12:5] seed, [4:3] stall, [2:1] corrupt lane+1, [0] toggle mode
  localparam logic [15:0] VECS [0:NV-1] = '{
    {1'b0, 2'd0, 8'hA5, 2'd0, 2'd0, 1'b0},
    {1'b0, 2'd1, 8'h00, 2'd1, 2'd0, 1'b0},
    {1'b0, 2'd3, 8'h00, 2'd3, 2'd0, 1'b0},
    {1'b1, 2'd2, 8'h5C, 2'd2, 2'd0, 1'b0},
    {1'b1, 2'd1, 8'h37, 2'd1, 2'd1, 1'b0},
    {1'b1, 2'd2, 8'h91, 2'd0, 2'd3, 1'b0},
    {1'b1, 2'd3, 8'h00, 2'd0, 2'd2, 1'b1},
    {1'b0, 2'd2, 8'h3E, 2'd3, 2'd0, 1'b1},
    {1'b1, 2'd1, 8'hC4, 2'd3, 2'd0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       decodeMode = 1'b0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] inData = '0;
  logic       outValid;
  logic       outReady = 1'b1;
  logic [7:0] outData;
  logic       done;
  logic       match;

  sector_scramble_cksum u_sector_scramble_cksum (
    .clk(clk), .rstN(rstN), .decodeMode(decodeMode),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .done(done), .match(match)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] plainBuf [0:SB-1];
  logic [7:0] scrBuf   [0:SB-1];
  logic [7:0] ckRef    [0:2];
  logic [7:0] inStream [0:SB+2];
  logic [7:0] expStream[0:SB+2];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic buildPlain(input logic [1:0] pat, input logic [7:0] seed);
    logic [7:0] x;
    x = seed | 8'h01;
    for (int i = 0; i < SB; i++) begin
      case (pat)
        2'd0: plainBuf[i] = seed;
        2'd1: plainBuf[i] = seed + 8'(i);
        2'd2: begin
          plainBuf[i] = x;
          x = {x[6:0], x[7] ^ x[5] ^ x[4] ^ x[3]};
        end
        default: plainBuf[i] = 8'hFF;
      endcase
    end
  endtask

  // Reference scrambler straight from the lane rules
  task automatic refEncode();
    logic [7:0] a, b, c, key;
    logic       cy;
    logic [8:0] s;
    a = 0; b = 0; c = 0; cy = 0;
    for (int i = 0; i < SB; i++) begin
      case (i % 3)
        0: begin
          cy  = c[7];
          c   = {c[6:0], c[7]};
          key = c;
          s   = {1'b0, a} + {1'b0, plainBuf[i]} + {8'b0, cy};
          a   = s[7:0]; cy = s[8];
        end
        1: begin
          key = a;
          s   = {1'b0, b} + {1'b0, plainBuf[i]} + {8'b0, cy};
          b   = s[7:0]; cy = s[8];
        end
        default: begin
          key = b;
          s   = {1'b0, c} + {1'b0, plainBuf[i]} + {8'b0, cy};
          c   = s[7:0]; cy = s[8];
        end
      endcase
      scrBuf[i] = plainBuf[i] ^ key;
    end
    ckRef[0] = a; ckRef[1] = b; ckRef[2] = c;
  endtask

  task automatic runSector(input int vIdx, input logic [15:0] v);
    bit dec, tog, expMatch, doneSeen, doneMatch, expectDone, encCSeen, holdPending, aborted;
    logic [1:0] stall, corrupt;
    logic [7:0] held;
    int nIn, nOut, inIdx, outIdx, cyc, streamErr, ckErr, doneCnt, timingBad, readyLeak, holdErr;
    int badAct, badExp;
    dec = v[15]; tog = v[0]; stall = v[4:3]; corrupt = v[2:1];
    buildPlain(v[14:13], v[12:5]);
    refEncode();
    if (dec) begin
      for (int i = 0; i < SB; i++) begin inStream[i] = scrBuf[i]; expStream[i] = plainBuf[i]; end
      for (int k = 0; k < 3; k++)
        inStream[SB+k] = ckRef[k] ^ ((int'(corrupt) == k + 1) ? 8'h10 : 8'h00);
      nIn = SB + 3; nOut = SB; expMatch = (corrupt == 2'd0);
    end else begin
      for (int i = 0; i < SB; i++) begin inStream[i] = plainBuf[i]; expStream[i] = scrBuf[i]; end
      for (int k = 0; k < 3; k++) expStream[SB+k] = ckRef[k];
      nIn = SB; nOut = SB + 3; expMatch = 1'b0;
    end
    inIdx = 0; outIdx = 0; cyc = 0; streamErr = 0; ckErr = 0; doneCnt = 0;
    timingBad = 0; readyLeak = 0; holdErr = 0; badAct = 0; badExp = 0;
    doneSeen = 0; doneMatch = 0; expectDone = 0; encCSeen = 0; holdPending = 0; aborted = 0;
    held = '0;
    while (!(doneSeen && outIdx == nOut)) begin
      @(negedge clk);
      cyc++;
      if (expectDone) begin
        if (!done) timingBad++;
        expectDone = 0;
      end
      if (done) begin doneSeen = 1; doneMatch = match; doneCnt++; end
      if (holdPending) begin
        if (!outValid || outData != held) holdErr++;
        holdPending = 0;
      end
      outReady   = !(stall[0] && (cyc % 3 == 0));
      inValid    = (inIdx < nIn) && !(stall[1] && (cyc % 4 == 1));
      inData     = (inIdx < nIn) ? inStream[inIdx] : 8'h00;
      decodeMode = (inIdx == 0) ? dec : (tog ? !dec : dec);
      #1;
      if (outValid) begin
        if (!dec && !encCSeen && outIdx == nOut - 1) begin
          encCSeen = 1;
          if (!done) timingBad++;
        end
        if (outReady) begin
          if (outIdx >= nOut) streamErr++;
          else if (outData != expStream[outIdx]) begin
            if (outIdx >= SB) ckErr++;
            else begin
              if (streamErr == 0) begin badAct = outData; badExp = expStream[outIdx]; end
              streamErr++;
            end
          end
          outIdx++;
        end else begin
          holdPending = 1; held = outData;
        end
      end
      if (!dec && inIdx >= nIn && !doneSeen && inReady) readyLeak++;
      if (inValid && inReady) begin
        if (dec && inIdx == nIn - 1) expectDone = 1;
        inIdx++;
      end
      if (cyc > 8000) begin aborted = 1; break; end
    end
    @(negedge clk);
    inValid = 0; outReady = 1;
    check(!aborted, "R11", $sformatf("vector %0d completed", vIdx), cyc, 8000);
    // R2/R3/R4 (encode) or R8 (decode); vectors after the first also rely on R5
    check(streamErr == 0, dec ? "R8/R5" : "R2/R3/R4/R5",
          $sformatf("vector %0d data stream", vIdx), badAct, badExp);
    if (tog) check(streamErr == 0, "R10", $sformatf("vector %0d mode held", vIdx), streamErr, 0);
    if (!dec) begin
      check(ckErr == 0, "R6", $sformatf("vector %0d checksum bytes", vIdx), ckErr, 0);
      check(readyLeak == 0, "R6", $sformatf("vector %0d input blocked", vIdx), readyLeak, 0);
    end
    check(doneCnt == 1, dec ? "R9" : "R7", $sformatf("vector %0d done count", vIdx), doneCnt, 1);
    check(doneMatch == expMatch, dec ? "R9" : "R7",
          $sformatf("vector %0d match", vIdx), doneMatch, expMatch);
    check(timingBad == 0, dec ? "R9" : "R7", $sformatf("vector %0d done timing", vIdx), timingBad, 0);
    if (stall[0]) check(holdErr == 0, "R11", $sformatf("vector %0d hold", vIdx), holdErr, 0);
  endtask

  task automatic summary();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(!outValid && !done && inReady, "R1", "reset state",
          {outValid, done, inReady}, 3'b001);
    for (int v = 0; v < NV; v++) runSector(v, VECS[v]);

    // Reset in the middle of an encode sector, then a clean decode sector
    decodeMode = 0; outReady = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      inValid = 1; inData = 8'(i * 7);
    end
    @(negedge clk);
    inValid = 0;
    rstN = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(!outValid && !done && inReady, "R1", "state after mid-sector reset",
          {outValid, done, inReady}, 3'b001);
    runSector(NV, VECS[3]);
    summary();
  end

endmodule